// File: doc/BRIEF.md
# Shared Event Counter CSR Unit

This block holds one 64-bit event counter and the two privilege enable masks that decide whether lower privilege levels may read it. Software reaches the counter through several CSR numbers. The machine cycle and retired-instruction numbers, their high-half numbers and their user-visible read-only copies all refer to the same physical register. The counter advances by one on each increment strobe. A CSR write has priority over an increment in the same cycle.

The core's CSR stage presents an address, write data, a write enable, the current privilege level and a width flag. The width flag selects either a 64-bit datapath or a 32-bit datapath. On a 32-bit datapath the counter is split into low and high words. A write to one word leaves the other word unchanged.

Reads are combinational from the current state. Writes take effect at the next clock edge. The performance-monitor counter and event numbers are fixed stubs that read as zero and discard writes. A user-level counter read that the active enable mask denies raises an access-fault flag and returns zero.

Top module: `evt_counter_csr`

## Requirements
- R1: After synchronous reset the counter and both enable masks are zero.
- R2: Numbers 0xB00 and 0xB02 (low) and 0xB80 and 0xB82 (high) all address the same counter. When access is allowed, 0xC00 and 0xC02 read it as well.
- R3: A write to 0xB00 or 0xB02 works as follows. With the width flag high, it replaces all 64 bits. With the width flag low, it replaces bits 31:0 with write data bits 31:0 and keeps bits 63:32.
- R4: A write to 0xB80 or 0xB82 replaces bits 63:32 with write data bits 31:0 and keeps bits 31:0, in either width mode.
- R5: Reads of the low numbers work as follows. With the width flag high they return all 64 bits. With the width flag low they return bits 31:0 zero-extended. Reads of the high numbers (0xB80, 0xB82, and 0xC80, 0xC82 when allowed) return bits 63:32 only when the width flag is low. With the width flag high they return 0.
- R6: Each cycle with the increment strobe high and no counter write adds one to the counter, modulo 2^64. A counter write in the same cycle wins over the increment.
- R7: The mask in effect depends on the privilege input. Privilege 0 (user) uses the user mask and privilege 1 (supervisor) uses the supervisor mask. Privileges 2 and 3 use all ones. Access is allowed when mask bit addr[4:0] is 1.
- R8: Numbers 0xC00–0xC1F, and 0xC80–0xC9F when the width flag is low, are user-level counter numbers. Reading one while access is denied drives the fault flag to 1 and read data to 0. The fault flag is 0 for every other number.
- R9: The user mask is written and read at 0x320, and the supervisor mask at 0x321. Each mask stores write data bits 31:0 without masking and reads back zero-extended.
- R10: The stub numbers read 0 whenever no fault is raised. These are the user counters 0xC01 and 0xC03–0xC1F with their high halves, the machine counters 0xB03–0xB1F and 0xB83–0xB9F, and the event selectors 0x323–0x33F.
- R11: Writes to any number other than 0xB00, 0xB02, 0xB80, 0xB82, 0x320 and 0x321 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR number being accessed |
| csr_wdata | input | 64 | Write data |
| csr_we | input | 1 | Write enable |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| wide_mode | input | 1 | 1 = 64-bit datapath, 0 = 32-bit datapath |
| inc | input | 1 | Increment strobe |
| csr_rdata | output | 64 | Read data for csr_addr |
| acc_fault | output | 1 | Denied user-level counter read |

## Verification
Read data and the fault flag depend only on the present inputs and the stored state. They are therefore due in the same cycle as the address, and the bench samples them one time unit after it drives the inputs, before the next rising edge. A write, an increment or a reset changes state at the next rising edge. The reference model applies it at that edge, so the first read that can show the new value comes one cycle after the stimulus. Every step compares both outputs against the model.

// File: rtl/evt_counter_pkg.sv
package evt_counter_pkg;

    localparam int CSR_AW = 12;

    typedef enum logic [1:0] {
        PL_USER  = 2'd0,
        PL_SUPER = 2'd1,
        PL_RSVD  = 2'd2,
        PL_MACH  = 2'd3
    } priv_lvl_e;

    localparam logic [CSR_AW-1:0] A_MCNT_LO0  = 12'hB00;
    localparam logic [CSR_AW-1:0] A_MCNT_LO1  = 12'hB02;
    localparam logic [CSR_AW-1:0] A_MCNT_HI0  = 12'hB80;
    localparam logic [CSR_AW-1:0] A_MCNT_HI1  = 12'hB82;
    localparam logic [CSR_AW-1:0] A_UCNT_LO0  = 12'hC00;
    localparam logic [CSR_AW-1:0] A_UCNT_LO1  = 12'hC02;
    localparam logic [CSR_AW-1:0] A_UCNT_HI0  = 12'hC80;
    localparam logic [CSR_AW-1:0] A_UCNT_HI1  = 12'hC82;
    localparam logic [CSR_AW-1:0] A_USER_SPAN_LO = 12'hC00;
    localparam logic [CSR_AW-1:0] A_USER_SPAN_HI = 12'hC1F;
    localparam logic [CSR_AW-1:0] A_USERH_SPAN_LO = 12'hC80;
    localparam logic [CSR_AW-1:0] A_USERH_SPAN_HI = 12'hC9F;
    localparam logic [CSR_AW-1:0] A_UMASK     = 12'h320;
    localparam logic [CSR_AW-1:0] A_SMASK     = 12'h321;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic wr_umask;
        logic wr_smask;
    } wr_dec_t;

    function automatic logic in_span(input logic [CSR_AW-1:0] a,
                                     input logic [CSR_AW-1:0] lo,
                                     input logic [CSR_AW-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic is_one_of(input logic [CSR_AW-1:0] a,
                                       input logic [CSR_AW-1:0] x,
                                       input logic [CSR_AW-1:0] y);
        return (a == x) || (a == y);
    endfunction

endpackage

// File: rtl/evt_wr_decode.sv
module evt_wr_decode
    import evt_counter_pkg::*;
(
    input  logic [CSR_AW-1:0] addr,
    input  logic              we,
    output wr_dec_t           dec
);
    always_comb begin
        dec.wr_lo    = we && is_one_of(addr, A_MCNT_LO0, A_MCNT_LO1);
        dec.wr_hi    = we && is_one_of(addr, A_MCNT_HI0, A_MCNT_HI1);
        dec.wr_umask = we && (addr == A_UMASK);
        dec.wr_smask = we && (addr == A_SMASK);
    end
endmodule

// File: rtl/evt_count_reg.sv
module evt_count_reg #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wide_mode,
    input  logic             inc,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt;
        if (wr_lo) begin
            if (wide_mode) cnt_nxt = wdata;
            else           cnt_nxt[HALF-1:0] = wdata[HALF-1:0];
        end else if (wr_hi) begin
            cnt_nxt[CNT_W-1:HALF] = wdata[HALF-1:0];
        end else if (inc) begin
            cnt_nxt = cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    assert_step_R6: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_lo && !wr_hi) |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!inc && !wr_lo && !wr_hi) |=> $stable(cnt));

    assert_hi_keep_R4: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (cnt[HALF-1:0] == $past(cnt[HALF-1:0])) &&
                  (cnt[CNT_W-1:HALF] == $past(wdata[HALF-1:0])));

    assert_narrow_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wide_mode) |=> (cnt[CNT_W-1:HALF] == $past(cnt[CNT_W-1:HALF])));
endmodule

// File: rtl/evt_mask_regs.sv
module evt_mask_regs #(
    parameter int EN_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_umask,
    input  logic            wr_smask,
    input  logic [EN_W-1:0] wdata,
    output logic [EN_W-1:0] umask,
    output logic [EN_W-1:0] smask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            umask <= '0;
            smask <= '0;
        end else begin
            if (wr_umask) umask <= wdata;
            if (wr_smask) smask <= wdata;
        end
    end

    assert_umask_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_umask |=> $stable(umask));

    assert_smask_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_smask |=> $stable(smask));
endmodule

// File: rtl/evt_read_gate.sv
module evt_read_gate
    import evt_counter_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int EN_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CSR_AW-1:0] addr,
    input  priv_lvl_e         priv,
    input  logic              wide_mode,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [EN_W-1:0]   umask,
    input  logic [EN_W-1:0]   smask,
    output logic [CNT_W-1:0]  rdata,
    output logic              fault
);
    localparam int HALF  = CNT_W / 2;
    localparam int IDX_W = $clog2(EN_W);

    logic [EN_W-1:0]  mask;
    logic             allowed;
    logic             user_lo, user_hi;
    logic [CNT_W-1:0] low_view, high_view;

    always_comb begin
        unique case (priv)
            PL_USER:  mask = umask;
            PL_SUPER: mask = smask;
            default:  mask = '1;
        endcase
        allowed   = mask[addr[IDX_W-1:0]];
        user_lo   = in_span(addr, A_USER_SPAN_LO, A_USER_SPAN_HI);
        user_hi   = !wide_mode && in_span(addr, A_USERH_SPAN_LO, A_USERH_SPAN_HI);
        fault     = (user_lo || user_hi) && !allowed;
        low_view  = wide_mode ? cnt : {{HALF{1'b0}}, cnt[HALF-1:0]};
        high_view = wide_mode ? '0 : {{HALF{1'b0}}, cnt[CNT_W-1:HALF]};
    end

    always_comb begin
        rdata = '0;
        if (fault) begin
            rdata = '0;
        end else if (is_one_of(addr, A_UCNT_LO0, A_UCNT_LO1) ||
                     is_one_of(addr, A_MCNT_LO0, A_MCNT_LO1)) begin
            rdata = low_view;
        end else if (is_one_of(addr, A_UCNT_HI0, A_UCNT_HI1) ||
                     is_one_of(addr, A_MCNT_HI0, A_MCNT_HI1)) begin
            rdata = high_view;
        end else if (addr == A_UMASK) begin
            rdata = CNT_W'(umask);
        end else if (addr == A_SMASK) begin
            rdata = CNT_W'(smask);
        end
    end

    assert_fault_zero_R8: assert property (@(posedge clk) disable iff (rst)
        fault |-> (rdata == '0));

    assert_narrow_read_R5: assert property (@(posedge clk) disable iff (rst)
        !wide_mode |-> (rdata[CNT_W-1:HALF] == '0));

    assert_mach_nofault_R7: assert property (@(posedge clk) disable iff (rst)
        (priv == PL_MACH) |-> !fault);
endmodule

// File: rtl/evt_counter_csr.sv
module evt_counter_csr
    import evt_counter_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int EN_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [CNT_W-1:0]  csr_wdata,
    input  logic              csr_we,
    input  logic [1:0]        priv,
    input  logic              wide_mode,
    input  logic              inc,
    output logic [CNT_W-1:0]  csr_rdata,
    output logic              acc_fault
);
    wr_dec_t          dec;
    logic [CNT_W-1:0] cnt;
    logic [EN_W-1:0]  umask, smask;
    priv_lvl_e        priv_e;

    assign priv_e = priv_lvl_e'(priv);

    evt_wr_decode u_dec (
        .addr (csr_addr),
        .we   (csr_we),
        .dec  (dec)
    );

    evt_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .wr_lo     (dec.wr_lo),
        .wr_hi     (dec.wr_hi),
        .wide_mode (wide_mode),
        .inc       (inc),
        .wdata     (csr_wdata),
        .cnt       (cnt)
    );

    evt_mask_regs #(.EN_W(EN_W)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .wr_umask (dec.wr_umask),
        .wr_smask (dec.wr_smask),
        .wdata    (csr_wdata[EN_W-1:0]),
        .umask    (umask),
        .smask    (smask)
    );

    evt_read_gate #(.CNT_W(CNT_W), .EN_W(EN_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .addr      (csr_addr),
        .priv      (priv_e),
        .wide_mode (wide_mode),
        .cnt       (cnt),
        .umask     (umask),
        .smask     (smask),
        .rdata     (csr_rdata),
        .fault     (acc_fault)
    );

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (cnt == '0) && (umask == '0) && (smask == '0));
endmodule

// File: tb/test_evt_counter_csr.sv
`timescale 1ns/1ps
module test_evt_counter_csr;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic        csr_we = 1'b0;
    logic [1:0]  priv = 2'd3;
    logic        wide_mode = 1'b1;
    logic        inc = 1'b0;
    logic [63:0] csr_rdata;
    logic        acc_fault;

    int checks = 0;
    int errors = 0;

    longint unsigned m_cnt = 0;
    int unsigned     m_um = 0;
    int unsigned     m_sm = 0;

    always #2.5 clk = ~clk;

    evt_counter_csr i_evt_counter_csr (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .priv(priv), .wide_mode(wide_mode), .inc(inc),
        .csr_rdata(csr_rdata), .acc_fault(acc_fault)
    );

    function automatic bit exp_fault(input int a, input int p, input bit w);
        int unsigned m;
        bit user_num;
        m = (p == 0) ? m_um : (p == 1) ? m_sm : 32'hFFFF_FFFF;
        user_num = (a >= 'hC00 && a <= 'hC1F) || (!w && a >= 'hC80 && a <= 'hC9F);
        return user_num && (((m >> (a % 32)) & 1) == 0);
    endfunction

    function automatic longint unsigned exp_read(input int a, input int p, input bit w);
        longint unsigned lo_v, hi_v;
        if (exp_fault(a, p, w)) return 0;
        lo_v = w ? m_cnt : (m_cnt % 64'h1_0000_0000);
        hi_v = w ? 0 : (m_cnt / 64'h1_0000_0000);
        if (a == 'hB00 || a == 'hB02 || a == 'hC00 || a == 'hC02) return lo_v;
        if (a == 'hB80 || a == 'hB82 || a == 'hC80 || a == 'hC82) return hi_v;
        if (a == 'h320) return m_um;
        if (a == 'h321) return m_sm;
        return 0;
    endfunction

    task automatic check(input string req, input longint unsigned got,
                         input longint unsigned exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", req, got, exp);
        end
    endtask

    // One cycle: drive inputs, compare the same-cycle read, then update the model at the edge.
    task automatic step(input string req, input int a, input longint unsigned wd,
                        input bit we, input int p, input bit w, input bit in_c);
        csr_addr = 12'(a); csr_wdata = wd; csr_we = we;
        priv = 2'(p); wide_mode = w; inc = in_c;
        #1;
        check({req, " rdata"}, csr_rdata, exp_read(a, p, w));
        check({req, " fault"}, {63'd0, acc_fault}, {63'd0, exp_fault(a, p, w)});
        @(posedge clk);
        if (we && (a == 'hB00 || a == 'hB02)) begin
            if (w) m_cnt = wd;
            else   m_cnt = (m_cnt / 64'h1_0000_0000) * 64'h1_0000_0000 + (wd % 64'h1_0000_0000);
        end else if (we && (a == 'hB80 || a == 'hB82)) begin
            m_cnt = (wd % 64'h1_0000_0000) * 64'h1_0000_0000 + (m_cnt % 64'h1_0000_0000);
        end else if (in_c) begin
            m_cnt = m_cnt + 1;
        end
        if (we && a == 'h320) m_um = int'(wd % 64'h1_0000_0000);
        if (we && a == 'h321) m_sm = int'(wd % 64'h1_0000_0000);
        @(negedge clk);
    endtask

    task automatic rd(input string req, input int a, input int p, input bit w);
        step(req, a, 0, 1'b0, p, w, 1'b0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd("R1 counter", 'hB00, 3, 1);
        rd("R1 umask", 'h320, 3, 1);
        rd("R1 smask", 'h321, 3, 1);
        // R6 increments, R2 aliases
        for (int i = 0; i < 5; i++) step("R6 inc", 'h000, 0, 1'b0, 3, 1, 1'b1);
        check("R6 model five", m_cnt, 64'd5);
        rd("R2 alias B02", 'hB02, 3, 1);
        rd("R2 alias C00", 'hC00, 3, 1);
        rd("R2 alias C02", 'hC02, 3, 1);
        // R3 wide write with simultaneous inc (R6 priority)
        step("R3 R6 wide write", 'hB02, 64'h1234_5678_9ABC_DEF0, 1'b1, 3, 1, 1'b1);
        rd("R3 wide readback", 'hB00, 3, 1);
        check("R6 priority", m_cnt, 64'h1234_5678_9ABC_DEF0);
        // R3 narrow write keeps upper word
        step("R3 narrow write", 'hB00, 64'hAAAA_BBBB_FFFF_FFFF, 1'b1, 3, 0, 1'b0);
        rd("R3 narrow low", 'hB00, 3, 0);
        rd("R5 narrow high", 'hB80, 3, 0);
        step("R6 carry", 'h000, 0, 1'b0, 3, 0, 1'b1);
        rd("R6 carry high", 'hB82, 3, 0);
        rd("R6 carry low", 'hB02, 3, 0);
        // R4 high write in both modes
        step("R4 high write", 'hB82, 64'h1111_2222_AAAA_5555, 1'b1, 3, 0, 1'b1);
        rd("R4 high readback", 'hB80, 3, 0);
        rd("R4 low kept", 'hB00, 3, 1);
        step("R4 high wide mode", 'hB80, 64'h0000_0000_0BAD_F00D, 1'b1, 3, 1, 1'b0);
        rd("R4 wide readback", 'hB00, 3, 1);
        rd("R5 high in wide", 'hB80, 3, 1);
        rd("R5 user high wide", 'hC80, 0, 1);
        // R8 denied user reads
        rd("R8 user C00 denied", 'hC00, 0, 1);
        rd("R8 super C02 denied", 'hC02, 1, 0);
        rd("R8 user high denied", 'hC80, 0, 0);
        // R9 masks
        step("R9 umask write", 'h320, 64'hFFFF_0000_0000_0005, 1'b1, 3, 1, 1'b0);
        rd("R9 umask readback", 'h320, 0, 1);
        step("R9 smask write", 'h321, 64'h0000_0000_DEAD_BEEF, 1'b1, 1, 1, 1'b0);
        rd("R9 smask readback", 'h321, 3, 1);
        // R7 mask selection
        rd("R7 user C00 allowed", 'hC00, 0, 1);
        rd("R7 user C02 allowed", 'hC02, 0, 0);
        rd("R7 user C01 denied", 'hC01, 0, 1);
        rd("R7 user C80 allowed", 'hC80, 0, 0);
        rd("R7 super C01 allowed", 'hC01, 1, 1);
        rd("R7 super C04 denied", 'hC04, 1, 1);
        rd("R7 priv2 all ones", 'hC04, 2, 1);
        rd("R7 machine all ones", 'hC1F, 3, 0);
        // R10 stubs
        rd("R10 user hpm", 'hC03, 1, 1);
        rd("R10 user hpm high", 'hC83, 3, 0);
        rd("R10 machine hpm", 'hB05, 3, 1);
        rd("R10 machine hpm high", 'hB9F, 3, 0);
        rd("R10 event sel", 'h330, 3, 1);
        // R11 ignored writes: state observed through reads afterwards
        step("R11 write hpm", 'hB05, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3, 1, 1'b0);
        step("R11 write event", 'h323, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3, 1, 1'b0);
        step("R11 write user alias", 'hC00, 64'h5A5A, 1'b1, 3, 1, 1'b0);
        rd("R11 counter kept", 'hB00, 3, 1);
        rd("R11 umask kept", 'h320, 3, 1);
        rd("R11 smask kept", 'h321, 3, 1);
        // R6 full wrap
        step("R6 set max", 'hB00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3, 1, 1'b0);
        step("R6 wrap", 'hB00, 0, 1'b0, 3, 1, 1'b1);
        rd("R6 wrapped", 'hB00, 3, 1);
        check("R6 wrap model", m_cnt, 64'd0);
        // R1 reset again clears all
        step("R4 preload", 'hB80, 64'h77, 1'b1, 3, 1, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        m_cnt = 0; m_um = 0; m_sm = 0;
        @(negedge clk);
        rst = 1'b0;
        rd("R1 counter after reset", 'hB00, 3, 1);
        rd("R1 umask after reset", 'h320, 3, 1);
        rd("R1 user denied after reset", 'hC00, 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule